// File: doc/BRIEF.md
# Paired-Instruction Accumulator Processor Core

This block is a small synchronous processor that computes in a single accumulator. Program and data share one memory of 40-bit words. Every word carries two 20-bit instructions. The core fetches a word once and executes its left (upper) instruction. It parks the right (lower) instruction in a buffer register and then executes it without a second fetch. The program counter therefore points at instruction pairs and steps once per pair.

Data words use sign-magnitude form: bit 39 is the sign (1 means negative) and bits 38:0 are the magnitude. The core supports five operations: load, add, subtract, store and an unconditional jump. It talks to a single-port synchronous memory that returns read data one cycle after a read strobe. An unknown opcode stops the core, and it stays stopped until reset.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `mem_rd`, `mem_wr` and `halted` are low. After reset the first memory access is a read of word 0.
- R2: In an instruction word, the left instruction is bits 39:20 (opcode 39:32, address 31:20) and the right instruction is bits 19:0 (opcode 19:12, address 11:0). The left instruction runs first and the right one runs second. Exactly one memory read fetches each pair, and the program counter then moves to the next word.
- R3: Opcode 0x01 (load) copies the operand word into the accumulator unchanged.
- R4: Opcode 0x05 (add) and opcode 0x06 (subtract) combine the accumulator with the operand in sign-magnitude. Magnitude carries beyond 39 bits are dropped, and a zero result always has sign 0.
- R5: Opcode 0x21 (store) writes the accumulator to the operand address with a `mem_wr` strobe that lasts exactly one cycle.
- R6: Opcode 0x0D (jump) loads the program counter from its address field. When the jump is the left instruction, the right instruction of the same word is discarded.
- R7: Addresses from 1000 to 4095 are unused. An operand at such an address causes no memory access: a load, add or subtract uses zero as the operand, and a store writes nothing. Fetching a pair from such an address halts the core.
- R8: Any opcode other than the five above raises `halted`. `halted` stays high until reset, and the core makes no further memory access.
- R9: `mem_rd` and `mem_wr` are never high together. Every read is followed by a cycle with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 40 | Accumulator value being stored |
| mem_rdata | input | 40 | Word returned by the memory |
| halted | output | 1 | Core stopped on an unknown opcode or an unused fetch address |

## Verification
The bench builds the core with its default parameters: 40-bit words, a 12-bit address field and 1000 populated words. Because the address field reaches past the populated range, random and directed programs can name operands and jump targets in the unused region, which exercises the suppression and halt paths. With a 39-bit magnitude, a directed case that adds one to the largest magnitude reaches the dropped carry. Random operand signs reach both the equal-sign and the opposite-sign branches, including exact cancellation to zero. A reference interpreter in the bench predicts the final memory image and the read and write counts, which exposes any extra fetch of the right instruction.

// File: rtl/acc_pkg.sv
// Package acc_pkg
// Shared opcode values and sequencer states for the accumulator core.
// Assumes an 8-bit opcode field at the top of every 20-bit instruction.
package acc_pkg;
    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [OPC_W-1:0] OPC_ADD   = 8'h05;
    localparam logic [OPC_W-1:0] OPC_SUB   = 8'h06;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 8'h0D;
    localparam logic [OPC_W-1:0] OPC_STORE = 8'h21;

    typedef enum logic [3:0] {
        ST_IAC,   // copy program counter into address register
        ST_IF,    // issue pair fetch
        ST_IFW,   // capture fetched word
        ST_DEC,   // split word, advance program counter
        ST_EXE,   // decode current opcode, issue operand access
        ST_OFW,   // capture operand
        ST_DO,    // update accumulator
        ST_NXT,   // switch to buffered right instruction or next pair
        ST_HALT   // stopped until reset
    } seq_state_t;
endpackage

// File: rtl/acc_alu.sv
// Module acc_alu
// Sign-magnitude adder/subtractor. The top bit is the sign and the rest is
// the magnitude. Carries out of the magnitude are dropped and a zero
// magnitude always leaves with a positive sign. Purely combinational.
module acc_alu #(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    localparam int MW = W - 1;

    logic          sa, sb, sy;
    logic [MW-1:0] ma, mb, my;

    // Pick the add or subtract path from the effective operand signs.
    always_comb begin
        sa = a[W-1];
        sb = b[W-1] ^ sub;
        ma = a[MW-1:0];
        mb = b[MW-1:0];
        if (sa == sb) begin
            my = ma + mb;
            sy = sa;
        end else if (ma >= mb) begin
            my = ma - mb;
            sy = sa;
        end else begin
            my = mb - ma;
            sy = sb;
        end
        if (my == '0) sy = 1'b0;
        y = {sy, my};
    end
endmodule

// File: rtl/acc_seq.sv
// Module acc_seq
// Control sequencer: walks fetch, decode, operand and execute steps and
// tracks whether the buffered right instruction is the one running.
// Assumes operand reads return data one cycle after the strobe.
module acc_seq
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc,
    input  logic             mar_ok,
    output seq_state_t       state,
    output logic             right_slot
);
    seq_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IAC:  nxt = ST_IF;
            ST_IF:   nxt = mar_ok ? ST_IFW : ST_HALT;
            ST_IFW:  nxt = ST_DEC;
            ST_DEC:  nxt = ST_EXE;
            ST_EXE: begin
                case (opc)
                    OPC_LOAD, OPC_ADD, OPC_SUB: nxt = ST_OFW;
                    OPC_STORE:                  nxt = ST_NXT;
                    OPC_JUMP:                   nxt = ST_IAC;
                    default:                    nxt = ST_HALT;
                endcase
            end
            ST_OFW:  nxt = ST_DO;
            ST_DO:   nxt = ST_NXT;
            ST_NXT:  nxt = right_slot ? ST_IAC : ST_EXE;
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IAC;
        else        state <= nxt;
    end

    // Slot flag: toggles at each pair step, cleared by a jump.
    always_ff @(posedge clk) begin
        if (!rst_n)
            right_slot <= 1'b0;
        else if (state == ST_NXT)
            right_slot <= ~right_slot;
        else if (state == ST_EXE && opc == OPC_JUMP)
            right_slot <= 1'b0;
    end
endmodule

// File: rtl/acc_core.sv
// Module acc_core
// Accumulator processor that executes two instructions per fetched word.
// Holds the datapath registers (accumulator, buffer, address, instruction,
// instruction buffer, program counter) and drives a single-port memory
// whose read data arrives one cycle after mem_rd.
module acc_core
    import acc_pkg::*;
#(
    parameter int WORD_W    = 40,
    parameter int ADDR_W    = 12,
    parameter int MEM_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    localparam int                INSN_W = WORD_W / 2;
    localparam logic [ADDR_W:0]   LIMIT  = (ADDR_W + 1)'(MEM_WORDS);

    logic [WORD_W-1:0] ac, mbr, alu_y;
    logic [ADDR_W-1:0] mar, pc;
    logic [INSN_W-1:0] ibr;
    logic [OPC_W-1:0]  ir;
    logic              mar_ok, right_slot, is_rd_op;
    seq_state_t        state;

    acc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .opc        (ir),
        .mar_ok     (mar_ok),
        .state      (state),
        .right_slot (right_slot)
    );

    acc_alu #(.W(WORD_W)) u_alu (
        .a   (ac),
        .b   (mbr),
        .sub (ir == OPC_SUB),
        .y   (alu_y)
    );

    // Address range and opcode class decode.
    always_comb begin
        mar_ok   = {1'b0, mar} < LIMIT;
        is_rd_op = (ir == OPC_LOAD) || (ir == OPC_ADD) || (ir == OPC_SUB);
    end

    // Memory strobes, only ever for populated addresses.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = ac;
        mem_rd    = mar_ok && ((state == ST_IF) || (state == ST_EXE && is_rd_op));
        mem_wr    = mar_ok && (state == ST_EXE) && (ir == OPC_STORE);
        halted    = (state == ST_HALT);
    end

    // Datapath register transfers, one group per sequencer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac  <= '0;
            mbr <= '0;
            mar <= '0;
            pc  <= '0;
            ibr <= '0;
            ir  <= '0;
        end else begin
            unique case (state)
                ST_IAC: mar <= pc;
                ST_IFW: mbr <= mem_rdata;
                ST_DEC: begin
                    ibr <= mbr[INSN_W-1:0];
                    ir  <= mbr[WORD_W-1 -: OPC_W];
                    mar <= mbr[WORD_W-OPC_W-1 -: ADDR_W];
                    pc  <= pc + 1'b1;
                end
                ST_EXE: if (ir == OPC_JUMP) pc <= mar;
                ST_OFW: mbr <= mar_ok ? mem_rdata : '0;
                ST_DO:  ac  <= (ir == OPC_LOAD) ? mbr : alu_y;
                ST_NXT: if (!right_slot) begin
                    ir  <= ibr[INSN_W-1 -: OPC_W];
                    mar <= ibr[ADDR_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_core_chk.sv
// Module acc_core_chk
// Port-level protocol checks for acc_core, bound to every instance.
// Assumes the synchronous active-low reset of the core.
module acc_core_chk #(
    parameter int ADDR_W    = 12,
    parameter int MEM_WORDS = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted
);
    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !(mem_rd || mem_wr));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (32'(mem_addr) < MEM_WORDS));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_rd || mem_wr));
endmodule

bind acc_core acc_core_chk #(
    .ADDR_W    (ADDR_W),
    .MEM_WORDS (MEM_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted)
);

// File: tb/test_acc_core.sv
// Bench for acc_core: memory model, reference interpreter, directed and
// seeded random programs.
module test_acc_core;
    localparam int NW = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [39:0] mem_wdata;
    logic [39:0] mem_rdata = '0;

    bit [39:0] mem    [0:NW-1];
    bit [39:0] gm     [0:NW-1];
    bit [39:0] init_m [0:NW-1];

    int n_tests = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0, bad_cnt = 0, first_addr = -1;

    acc_core i_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always #4 clk = ~clk;

    // Synchronous memory model and access counters.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rd && mem_wr) bad_cnt++;
            if (mem_rd) begin
                rd_cnt++;
                if (first_addr < 0) first_addr = int'(mem_addr);
                if (mem_addr < NW) mem_rdata <= mem[mem_addr];
                else begin mem_rdata <= '0; bad_cnt++; end
            end
            if (mem_wr) begin
                wr_cnt++;
                if (mem_addr < NW) mem[mem_addr] = mem_wdata;
                else bad_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [19:0] ins(input bit [7:0] op, input int a);
        return {op, a[11:0]};
    endfunction

    function automatic bit [39:0] sm(input bit neg, input longint mag);
        return {neg, mag[38:0]};
    endfunction

    // Reference arithmetic via signed integers.
    function automatic bit [39:0] smop(input bit [39:0] a, input bit [39:0] b, input bit sub);
        longint va, vb, r, m;
        va = longint'(a[38:0]); if (a[39]) va = -va;
        vb = longint'(b[38:0]); if (b[39] ^ sub) vb = -vb;
        r = va + vb;
        m = (r < 0 ? -r : r) & ((64'd1 << 39) - 1);
        return {(r < 0) && (m != 0), m[38:0]};
    endfunction

    // Reference interpreter on gm; counts expected reads and writes.
    task automatic gold_run(output int rds, output int wrs);
        int pc = 0, steps = 0;
        bit [39:0] ac = '0, w, opnd;
        bit stop = 0;
        rds = 0; wrs = 0;
        while (!stop && steps < 100000) begin
            steps++;
            if (pc >= NW) begin stop = 1; break; end
            w = gm[pc]; rds++; pc++;
            for (int s = 0; s < 2; s++) begin
                bit [19:0] iw;
                bit [7:0]  op;
                int        a;
                bit        jumped = 0;
                iw = (s == 0) ? w[39:20] : w[19:0];
                op = iw[19:12]; a = int'(iw[11:0]);
                opnd = '0;
                if ((op == 8'h01 || op == 8'h05 || op == 8'h06) && a < NW) begin
                    opnd = gm[a]; rds++;
                end
                case (op)
                    8'h01: ac = opnd;
                    8'h05: ac = smop(ac, opnd, 1'b0);
                    8'h06: ac = smop(ac, opnd, 1'b1);
                    8'h21: if (a < NW) begin gm[a] = ac; wrs++; end
                    8'h0D: begin pc = a; jumped = 1; end
                    default: stop = 1;
                endcase
                if (stop || jumped) break;
            end
        end
    endtask

    task automatic clr();
        for (int i = 0; i < NW; i++) init_m[i] = '0;
    endtask

    // Load memory, run the core to halt, compare against the interpreter.
    task automatic run_prog(input string tag);
        int grd, gwr, cyc, miss, miss_a, rd_hold;
        for (int i = 0; i < NW; i++) begin mem[i] = init_m[i]; gm[i] = init_m[i]; end
        gold_run(grd, gwr);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs quiet during reset
        chk(!mem_rd && !mem_wr && !halted, "R1", {tag, " reset outputs"},
            {mem_rd, mem_wr, halted}, 0);
        rd_cnt = 0; wr_cnt = 0; bad_cnt = 0; first_addr = -1;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(cyc < 20000, "R8", {tag, " reaches halt"}, cyc, 0);
        // R1 first access is the fetch of word 0
        chk(first_addr == 0, "R1", {tag, " first fetch address"}, first_addr, 0);
        miss = 0; miss_a = 0;
        for (int i = 0; i < NW; i++)
            if (mem[i] != gm[i]) begin if (miss == 0) miss_a = i; miss++; end
        chk(miss == 0, "R3", {tag, " memory image"}, mem[miss_a], gm[miss_a]);
        // R2 one read per pair plus operand reads
        chk(rd_cnt == grd, "R2", {tag, " read count"}, rd_cnt, grd);
        chk(wr_cnt == gwr, "R5", {tag, " write count"}, wr_cnt, gwr);
        chk(bad_cnt == 0, "R7", {tag, " unused-address or overlapped access"}, bad_cnt, 0);
        rd_hold = rd_cnt + wr_cnt;
        repeat (10) @(negedge clk);
        // R8 halted stays high and the core stays silent
        chk(halted && (rd_cnt + wr_cnt == rd_hold), "R8", {tag, " halt holds"},
            rd_cnt + wr_cnt, rd_hold);
    endtask

    function automatic bit [19:0] rnd_ins(input int p, input int np);
        int k = $urandom_range(0, 9);
        int da = 500 + $urandom_range(0, 31);
        case (k)
            0, 1: return ins(8'h01, da);
            2, 3: return ins(8'h05, da);
            4, 9: return ins(8'h06, da);
            5, 6: return ins(8'h21, da);
            7:    return (p + 1 < np) ? ins(8'h0D, p + 1) : ins(8'h01, da);
            default: return ins($urandom_range(0, 1) ? 8'h01 : 8'h21,
                                1000 + $urandom_range(0, 3000));
        endcase
    endfunction

    // Global watchdog.
    initial begin
        #(8 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));

        // R3 R4 load then add, store result
        clr();
        init_m[0] = {ins(8'h01, 500), ins(8'h05, 501)};
        init_m[1] = {ins(8'h21, 502), ins(8'hFF, 0)};
        init_m[500] = 40'd3; init_m[501] = 40'd4;
        run_prog("load-add");
        chk(mem[502] == 40'd7, "R4", "3+4", mem[502], 7);
        chk(rd_cnt == 4, "R2", "pair fetches not repeated", rd_cnt, 4);

        // R4 cancellation gives positive zero, both orders of sign
        clr();
        init_m[0] = {ins(8'h01, 500), ins(8'h06, 501)};
        init_m[1] = {ins(8'h21, 502), ins(8'h01, 503)};
        init_m[2] = {ins(8'h05, 501), ins(8'h21, 504)};
        init_m[3] = {ins(8'hFF, 0), ins(8'hFF, 0)};
        init_m[500] = sm(0, 5); init_m[501] = sm(0, 5); init_m[503] = sm(1, 5);
        init_m[502] = '1; init_m[504] = '1;
        run_prog("zero-sign");
        chk(mem[502] == '0, "R4", "5-5 positive zero", mem[502], 0);
        chk(mem[504] == '0, "R4", "-5+5 positive zero", mem[504], 0);

        // R4 magnitude carry dropped
        clr();
        init_m[0] = {ins(8'h01, 500), ins(8'h05, 501)};
        init_m[1] = {ins(8'h21, 502), ins(8'h06, 503)};
        init_m[2] = {ins(8'h21, 504), ins(8'hFF, 0)};
        init_m[500] = sm(0, (64'd1 << 39) - 1); init_m[501] = sm(0, 1);
        init_m[503] = sm(0, 2); init_m[502] = '1;
        run_prog("overflow");
        chk(mem[502] == '0, "R4", "max+1 wraps to zero", mem[502], 0);
        chk(mem[504] == sm(1, 2), "R4", "0-2 negative", mem[504], sm(1, 2));

        // R6 jump skips the right instruction and the next word
        clr();
        init_m[0] = {ins(8'h0D, 2), ins(8'h21, 600)};
        init_m[1] = {ins(8'h21, 601), ins(8'hFF, 0)};
        init_m[2] = {ins(8'h01, 500), ins(8'h21, 602)};
        init_m[3] = {ins(8'hFF, 0), ins(8'h00, 0)};
        init_m[500] = sm(1, 77); init_m[600] = 40'd11; init_m[601] = 40'd12;
        run_prog("jump");
        chk(mem[600] == 40'd11, "R6", "right of jump discarded", mem[600], 11);
        chk(mem[601] == 40'd12, "R6", "skipped word untouched", mem[601], 12);
        chk(mem[602] == sm(1, 77), "R6", "target executed", mem[602], sm(1, 77));

        // R7 unused operand and fetch addresses
        clr();
        init_m[0] = {ins(8'h01, 500), ins(8'h21, 1500)};
        init_m[1] = {ins(8'h01, 2000), ins(8'h21, 603)};
        init_m[2] = {ins(8'h0D, 1000), ins(8'h21, 604)};
        init_m[500] = 40'd9; init_m[603] = 40'd5; init_m[604] = 40'd6;
        run_prog("unused");
        chk(wr_cnt == 1, "R7", "store to unused address suppressed", wr_cnt, 1);
        chk(mem[603] == '0, "R7", "unused load gives zero", mem[603], 0);
        chk(mem[604] == 40'd6, "R7", "fetch from unused halts", mem[604], 6);

        // R8 unknown opcode as the very first instruction
        clr();
        init_m[0] = {ins(8'h02, 500), ins(8'h21, 500)};
        init_m[500] = 40'd1;
        run_prog("unknown");
        chk(wr_cnt == 0 && rd_cnt == 1, "R8", "stop before right instruction",
            rd_cnt + wr_cnt, 1);

        // R2 R3 R4 R5 R6 R7 random programs
        for (int t = 0; t < 25; t++) begin
            int np = $urandom_range(4, 14);
            clr();
            for (int d = 500; d < 532; d++) begin
                bit [63:0] v = {$urandom(), $urandom()};
                init_m[d] = v[39:0];
                if ($urandom_range(0, 3) == 0) init_m[d][38:8] = '0;
            end
            for (int p = 0; p < np; p++)
                init_m[p] = {rnd_ins(p, np),
                             (p == np - 1) ? ins(8'hFF, 0) : rnd_ins(p, np)};
            run_prog($sformatf("random%0d", t));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule